// File: doc/BRIEF.md
# Management Mailbox Register File (Target Side)

This block is the device end of a byte-wide management mailbox. An external initiator reaches it through a plain register-bus slave port that carries an address, write data, a write strobe and a read strobe. Registered read data appears one cycle after the read strobe. The initiator loads a command byte and a 32-bit argument into the inbound message bytes. It then rings a doorbell by writing a trigger code to the software-interrupt register. The block passes the command and argument to a firmware-side port as a single-cycle request.

When the firmware side finishes, it returns a 32-bit result with a one-cycle done strobe. The block stores the result in the outbound message bytes and sets a completion flag in the status register. That flag drives an alert output unless the control register masks it. The initiator clears the flag by writing a one to it.

The block passes command identifiers through without interpreting them. The identifiers in use are: 0x01 read power consumption, 0x02 write power limit, 0x03 read power limit, and 0x04 read maximum power limit.

Top module: `mgmt_mailbox`

## Requirements
- R1: After reset, control reads 0x10 (bit 4, the alert mask, set), status reads 0x00, every message byte reads 0x00, and alert_o and fw_req are 0.
- R2: Inbound bytes 0 to 7 at 0x38 to 0x3F are read/write, and 0x3F may hold a pending marker such as 0x80. A read strobe in one cycle presents the addressed byte on bus_rdata from the next cycle, and bus_rdata holds its value while no read is strobed.
- R3: Writing exactly 0x01 to 0x40 while no request is outstanding raises fw_req for exactly one cycle, starting the cycle after the write. During that cycle fw_cmd carries byte 0x38 and fw_arg carries {0x3C,0x3B,0x3A,0x39}, with the least significant byte at 0x39. Any other value written to 0x40 starts nothing.
- R4: A trigger written while a request is outstanding (from the request until its done strobe) is ignored and produces no fw_req.
- R5: A done strobe for an outstanding request loads fw_result into outbound bytes 0x31 to 0x34, least significant byte at 0x31. Bytes 0x30 and 0x35 to 0x37 always read 0x00. Bus writes to outbound bytes are ignored, and a done strobe with no request outstanding changes nothing.
- R6: Status bit 1 is set by an accepted done strobe and cleared only by a status write with bit 1 high. A status write with bit 1 low leaves it unchanged, the other status bits read 0, and when a set and a clear meet in the same cycle the set wins.
- R7: Control is a read/write byte. alert_o is 1 exactly when status bit 1 is 1 and control bit 4 is 0.
- R8: Reads of unmapped addresses and of 0x40 return 0x00, and writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| fw_req | output | 1 | One-cycle command request to firmware side |
| fw_cmd | output | 8 | Command byte captured at the trigger |
| fw_arg | output | 32 | Argument captured at the trigger |
| fw_done | input | 1 | One-cycle completion strobe from firmware side |
| fw_result | input | 32 | Result word, valid with fw_done |
| alert_o | output | 1 | Completion alert, gated by the mask |

## Verification
The bench goes after the doorbell corner cases. A retrigger while busy must not emit a second request, and a design that failed here would issue a duplicate command that overwrote the firmware's argument. A non-0x01 trigger value must start nothing, and a done strobe with no request outstanding must leave the outbound bytes and status untouched; a broken design would latch stray results or raise a false alert. The bench also drives a done strobe and a status clear in the same cycle, where a wrong priority would lose a completion. It checks that writes with bit 1 low and writes to outbound or unmapped addresses have no effect, which exposes decode aliasing. A mask-polarity error shows up as alert_o rising while control bit 4 is still set.

// File: rtl/mbox_pkg.sv
// Shared constants for the management mailbox: address map, reset values,
// bit positions. Assumes byte-wide registers and 8-bit addressing.
package mbox_pkg;
    localparam int CTRL_ADDR     = 'h01;
    localparam int STAT_ADDR     = 'h02;
    localparam int OUT_BASE      = 'h30;
    localparam int IN_BASE       = 'h38;
    localparam int DOORBELL_ADDR = 'h40;
    localparam int TRIG_CODE     = 'h01;
    localparam int CTRL_RESET    = 'h10;
    localparam int MASK_BIT      = 4;
    localparam int ALERT_BIT     = 1;
endpackage

// File: rtl/mbox_msg_bank.sv
// Inbound and outbound message byte storage.
// Inbound bytes are written from the bus. Outbound bytes 1..ARG_BYTES load a
// result word on out_load, and the remaining outbound bytes are constant zero.
// Assumes NBYTES > ARG_BYTES.
module mbox_msg_bank #(
    parameter int NBYTES    = 8,
    parameter int DW        = 8,
    parameter int ARG_BYTES = 4,
    localparam int IW       = $clog2(NBYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_we,
    input  logic [IW-1:0]           in_idx,
    input  logic [DW-1:0]           in_wdata,
    input  logic                    out_load,
    input  logic [ARG_BYTES*DW-1:0] out_word,
    output logic [NBYTES*DW-1:0]    in_bytes,
    output logic [NBYTES*DW-1:0]    out_bytes
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_in
        // Inbound byte i: bus write when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                in_bytes[i*DW +: DW] <= '0;
            else if (in_we && in_idx == IW'(i))
                in_bytes[i*DW +: DW] <= in_wdata;
        end
    end

    for (genvar j = 0; j < NBYTES; j++) begin : g_out
        if (j >= 1 && j <= ARG_BYTES) begin : g_res
            // Outbound result byte j: loads on completion.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    out_bytes[j*DW +: DW] <= '0;
                else if (out_load)
                    out_bytes[j*DW +: DW] <= out_word[(j-1)*DW +: DW];
            end
        end else begin : g_zero
            assign out_bytes[j*DW +: DW] = '0;
        end
    end
endmodule

// File: rtl/mbox_doorbell.sv
// Doorbell sequencer. A trigger while idle captures the command and argument,
// pulses req for one cycle and marks the request outstanding until done_in.
// Triggers while outstanding are dropped; done_in while idle is dropped.
module mbox_doorbell #(
    parameter int CW = 8,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [CW-1:0] cmd_in,
    input  logic [AW-1:0] arg_in,
    input  logic          done_in,
    output logic          req,
    output logic [CW-1:0] cmd,
    output logic [AW-1:0] arg,
    output logic          busy,
    output logic          done_ok
);
    logic start;

    assign start   = trig && !busy;
    assign done_ok = done_in && busy;

    // Request pulse and outstanding flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            busy <= 1'b0;
        end else begin
            req <= start;
            if (start)
                busy <= 1'b1;
            else if (done_ok)
                busy <= 1'b0;
        end
    end

    // Snapshot of the command and argument at the accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd <= '0;
            arg <= '0;
        end else if (start) begin
            cmd <= cmd_in;
            arg <= arg_in;
        end
    end
endmodule

// File: rtl/mbox_ctrl_stat.sv
// Control and status registers plus the alert gate.
// Status holds only the completion flag; a set wins over a same-cycle clear.
module mbox_ctrl_stat
    import mbox_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic          stat_we,
    input  logic [DW-1:0] wdata,
    input  logic          set_flag,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] stat_q,
    output logic          flag,
    output logic          alert_o
);
    // Control register, plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= DW'(CTRL_RESET);
        else if (ctrl_we)
            ctrl_q <= wdata;
    end

    // Completion flag: set by done, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_flag)
            flag <= 1'b1;
        else if (stat_we && wdata[ALERT_BIT])
            flag <= 1'b0;
    end

    // Status view and alert gate.
    always_comb begin
        stat_q            = '0;
        stat_q[ALERT_BIT] = flag;
        alert_o           = flag && !ctrl_q[MASK_BIT];
    end
endmodule

// File: rtl/mgmt_mailbox.sv
// Management mailbox target: address decode, registered read mux, and
// wiring between the message bank, doorbell and control/status blocks.
// Assumes a single-cycle bus: one access per strobe, read data next cycle.
module mgmt_mailbox
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int MSG_BYTES = 8,
    parameter int ARG_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic                        bus_we,
    input  logic                        bus_re,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        fw_req,
    output logic [DATA_W-1:0]           fw_cmd,
    output logic [ARG_BYTES*DATA_W-1:0] fw_arg,
    input  logic                        fw_done,
    input  logic [ARG_BYTES*DATA_W-1:0] fw_result,
    output logic                        alert_o
);
    localparam int IDX_W = $clog2(MSG_BYTES);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int ARG_W = ARG_BYTES * DATA_W;

    logic                        sel_ctrl, sel_stat, sel_in, sel_out, sel_bell;
    logic [IDX_W-1:0]            idx;
    logic [MSG_BYTES*DATA_W-1:0] in_bytes, out_bytes;
    logic [DATA_W-1:0]           ctrl_q, stat_q, rd_next;
    logic                        busy, stat_alert, done_ok, trig;

    // Address decode.
    always_comb begin
        idx      = bus_addr[IDX_W-1:0];
        sel_ctrl = bus_addr == ADDR_W'(CTRL_ADDR);
        sel_stat = bus_addr == ADDR_W'(STAT_ADDR);
        sel_bell = bus_addr == ADDR_W'(DOORBELL_ADDR);
        sel_in   = bus_addr[ADDR_W-1:IDX_W] == TAG_W'(IN_BASE >> IDX_W);
        sel_out  = bus_addr[ADDR_W-1:IDX_W] == TAG_W'(OUT_BASE >> IDX_W);
        trig     = bus_we && sel_bell && bus_wdata == DATA_W'(TRIG_CODE);
    end

    mbox_msg_bank #(
        .NBYTES    (MSG_BYTES),
        .DW        (DATA_W),
        .ARG_BYTES (ARG_BYTES)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_we     (bus_we && sel_in),
        .in_idx    (idx),
        .in_wdata  (bus_wdata),
        .out_load  (done_ok),
        .out_word  (fw_result),
        .in_bytes  (in_bytes),
        .out_bytes (out_bytes)
    );

    mbox_doorbell #(
        .CW (DATA_W),
        .AW (ARG_W)
    ) u_bell (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .cmd_in  (in_bytes[DATA_W-1:0]),
        .arg_in  (in_bytes[DATA_W +: ARG_W]),
        .done_in (fw_done),
        .req     (fw_req),
        .cmd     (fw_cmd),
        .arg     (fw_arg),
        .busy    (busy),
        .done_ok (done_ok)
    );

    mbox_ctrl_stat #(
        .DW (DATA_W)
    ) u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (bus_we && sel_ctrl),
        .stat_we  (bus_we && sel_stat),
        .wdata    (bus_wdata),
        .set_flag (done_ok),
        .ctrl_q   (ctrl_q),
        .stat_q   (stat_q),
        .flag     (stat_alert),
        .alert_o  (alert_o)
    );

    // Read mux; unmapped and doorbell read as zero.
    always_comb begin
        rd_next = '0;
        if (sel_ctrl)
            rd_next = ctrl_q;
        else if (sel_stat)
            rd_next = stat_q;
        else if (sel_in)
            rd_next = in_bytes[idx*DATA_W +: DATA_W];
        else if (sel_out)
            rd_next = out_bytes[idx*DATA_W +: DATA_W];
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_re)
            bus_rdata <= rd_next;
    end
endmodule

// File: rtl/mgmt_mailbox_chk.sv
// Protocol checker for mgmt_mailbox, bound to every instance.
// Observes ports plus the outstanding flag, completion flag and mask bit.
module mgmt_mailbox_chk
    import mbox_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_we,
    input logic       fw_req,
    input logic       fw_done,
    input logic       alert_o,
    input logic       busy,
    input logic       stat_alert,
    input logic       mask
);
    // R3
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fw_req |=> !fw_req);

    // R4
    no_req_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fw_done) |=> !fw_req);

    // R6
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fw_done) |=> stat_alert);

    // R6
    flag_clear_by_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_alert) |-> $past(bus_we && bus_addr == 8'(STAT_ADDR) && bus_wdata[ALERT_BIT]));

    // R7
    alert_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |-> (stat_alert && !mask));
endmodule

bind mgmt_mailbox mgmt_mailbox_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .fw_req     (fw_req),
    .fw_done    (fw_done),
    .alert_o    (alert_o),
    .busy       (busy),
    .stat_alert (stat_alert),
    .mask       (ctrl_q[4])
);

// File: tb/mgmt_mailbox_tb.sv
// Bench: behavioural reference model compared every clock plus directed checks.
module mgmt_mailbox_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0, wdata = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [7:0]  rdata, fw_cmd;
    logic        fw_req, alert_o;
    logic [31:0] fw_arg;
    logic        fw_done = 1'b0;
    logic [31:0] fw_result = '0;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";

    always #(CLK_P/2) clk = ~clk;

    mgmt_mailbox u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_re    (re),
        .bus_rdata (rdata),
        .fw_req    (fw_req),
        .fw_cmd    (fw_cmd),
        .fw_arg    (fw_arg),
        .fw_done   (fw_done),
        .fw_result (fw_result),
        .alert_o   (alert_o)
    );

    // Reference model state
    logic [7:0]  m_ctrl, m_rd, m_cmd;
    logic        m_flag, m_busy, m_req;
    logic [7:0]  m_in [8];
    logic [7:0]  m_out[8];
    logic [31:0] m_arg;

    always @(posedge clk) begin
        logic acc;
        if (!rst_n) begin
            m_ctrl = 8'h10; m_flag = 0; m_busy = 0; m_req = 0; m_rd = 0;
            m_cmd = 0; m_arg = 0;
            foreach (m_in[k]) begin m_in[k] = 0; m_out[k] = 0; end
        end else begin
            if (re) begin
                if (addr == 8'h01) m_rd = m_ctrl;
                else if (addr == 8'h02) m_rd = {6'b0, m_flag, 1'b0};
                else if (addr >= 8'h30 && addr <= 8'h37) m_rd = m_out[addr - 8'h30];
                else if (addr >= 8'h38 && addr <= 8'h3F) m_rd = m_in[addr - 8'h38];
                else m_rd = 8'h00;
            end
            acc = we && addr == 8'h40 && wdata == 8'h01 && !m_busy;
            m_req = acc;
            if (acc) begin
                m_cmd = m_in[0];
                m_arg = {m_in[4], m_in[3], m_in[2], m_in[1]};
                m_busy = 1;
            end
            if (we) begin
                if (addr == 8'h01) m_ctrl = wdata;
                else if (addr == 8'h02 && wdata[1]) m_flag = 0;
                else if (addr >= 8'h38 && addr <= 8'h3F) m_in[addr - 8'h38] = wdata;
            end
            if (fw_done && m_busy && !acc) begin
                m_busy = 0;
                m_flag = 1;
                for (int k = 0; k < 4; k++) m_out[k+1] = fw_result[k*8 +: 8];
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(32'(rdata), 32'(m_rd), {phase, " rdata"});
            chk(32'(fw_req), 32'(m_req), {phase, " fw_req"});
            chk(32'(alert_o), 32'(m_flag && !m_ctrl[4]), {phase, " alert"});
            if (m_req) begin
                chk(32'(fw_cmd), 32'(m_cmd), {phase, " fw_cmd"});
                chk(fw_arg, m_arg, {phase, " fw_arg"});
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1;
        @(negedge clk); we = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); addr = a; re = 1;
        @(negedge clk); re = 0;
        chk(32'(rdata), 32'(exp), tag);
    endtask

    task automatic done(input logic [31:0] r);
        @(negedge clk); fw_done = 1; fw_result = r;
        @(negedge clk); fw_done = 0;
    endtask

    task automatic load(input logic [7:0] c, input logic [31:0] a);
        wr(8'h3F, 8'h80);
        wr(8'h38, c);
        for (int k = 0; k < 4; k++) wr(8'h39 + 8'(k), a[k*8 +: 8]);
    endtask

    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        phase = "R1";
        chk(32'(alert_o), 0, "R1 alert");
        chk(32'(fw_req), 0, "R1 fw_req");
        rd(8'h01, 8'h10, "R1 ctrl");
        rd(8'h02, 8'h00, "R1 status");
        rd(8'h38, 8'h00, "R1 inbound0");
        rd(8'h3F, 8'h00, "R1 inbound7");
        rd(8'h31, 8'h00, "R1 outbound1");

        // R2 inbound read/write, read hold
        phase = "R2";
        for (int k = 0; k < 8; k++) wr(8'h38 + 8'(k), 8'hA0 + 8'(k));
        for (int k = 0; k < 8; k++) rd(8'h38 + 8'(k), 8'hA0 + 8'(k), "R2 inbound");
        repeat (2) @(negedge clk);
        chk(32'(rdata), 32'hA7, "R2 hold");

        // R3 doorbell request
        phase = "R3";
        load(8'h02, 32'h12345678);
        rd(8'h3F, 8'h80, "R2 pending marker");
        wr(8'h40, 8'h01);
        chk(32'(fw_req), 1, "R3 req");
        chk(32'(fw_cmd), 32'h02, "R3 cmd");
        chk(fw_arg, 32'h12345678, "R3 arg");
        @(negedge clk);
        chk(32'(fw_req), 0, "R3 single cycle");

        // R4 retrigger while outstanding
        phase = "R4";
        wr(8'h38, 8'h03);
        wr(8'h40, 8'h01);
        chk(32'(fw_req), 0, "R4 retrigger ignored");
        repeat (3) @(negedge clk);

        // R5 completion data
        phase = "R5";
        done(32'hCAFEF00D);
        rd(8'h31, 8'h0D, "R5 out1");
        rd(8'h32, 8'hF0, "R5 out2");
        rd(8'h33, 8'hFE, "R5 out3");
        rd(8'h34, 8'hCA, "R5 out4");
        rd(8'h30, 8'h00, "R5 out0");
        rd(8'h35, 8'h00, "R5 out5");
        wr(8'h31, 8'hFF);
        rd(8'h31, 8'h0D, "R5 outbound write ignored");

        // R6 / R7 status and alert
        phase = "R6";
        rd(8'h02, 8'h02, "R6 flag set");
        chk(32'(alert_o), 0, "R7 masked");
        phase = "R7";
        wr(8'h01, 8'h00);
        chk(32'(alert_o), 1, "R7 unmasked alert");
        rd(8'h01, 8'h00, "R7 ctrl rw");
        phase = "R6";
        wr(8'h02, 8'hFD);
        chk(32'(alert_o), 1, "R6 write bit1 low keeps flag");
        wr(8'h02, 8'h02);
        chk(32'(alert_o), 0, "R6 w1c");
        rd(8'h02, 8'h00, "R6 cleared");

        // R5 done while idle ignored
        phase = "R5";
        done(32'h11111111);
        rd(8'h31, 8'h0D, "R5 idle done ignored");
        rd(8'h02, 8'h00, "R5 idle done no flag");

        // R3 wrong trigger code
        phase = "R3";
        wr(8'h40, 8'h03);
        chk(32'(fw_req), 0, "R3 bad code");
        @(negedge clk);
        chk(32'(fw_req), 0, "R3 bad code later");

        // R8 unmapped
        phase = "R8";
        wr(8'h50, 8'hFF);
        wr(8'h00, 8'hFF);
        wr(8'h03, 8'hFF);
        rd(8'h50, 8'h00, "R8 unmapped read");
        rd(8'h40, 8'h00, "R8 doorbell read");
        rd(8'h01, 8'h00, "R8 ctrl untouched");
        rd(8'h38, 8'h03, "R8 inbound untouched");

        // R6 done and clear in the same cycle: set wins; R3 new command
        phase = "R6";
        load(8'h04, 32'h00000001);
        wr(8'h40, 8'h01);
        chk(32'(fw_cmd), 32'h04, "R3 second cmd");
        @(negedge clk); addr = 8'h02; wdata = 8'h02; we = 1; fw_done = 1; fw_result = 32'h0000BEEF;
        @(negedge clk); we = 0; fw_done = 0;
        chk(32'(alert_o), 1, "R6 set wins");
        rd(8'h02, 8'h02, "R6 set wins status");
        rd(8'h32, 8'hBE, "R5 second result");
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule